// File: doc/BRIEF.md
# Three-Phase Level-Sensitive Scan Register

This block is a scan register in which every stored bit sits in a pair of level-sensitive latches. The first latch of each pair has two data ports. The system port is opened by clock phase C. The scan port is opened by clock phase A. The second latch copies the first while phase B is high. The block has no scan-enable multiplexer. Whether a stage captures system data or shifts scan data depends only on which phase is pulsed before B.

An internal sequencer builds the three phases from the system clock, and every phase is driven straight from a flop. A user issues one of three commands:
- capture: a C pulse, then a B pulse.
- shift: a counted run of A/B pulse pairs.
- flush: A and B are held high together, so the whole chain becomes transparent from `scan_in` to `scan_out`.

`busy` marks a sequence in progress. A typical test loop is: capture the logic's response, shift it out while the next pattern shifts in, then capture again.

Top module: `lssd_scan_reg`

## Requirements
- R1: After reset `busy` is 0 and no phase is pulsed until a command is accepted.
- R2: A capture command (code 2'b01) pulses C, then B, and leaves `par_q` equal to the `par_d` value present during the C pulse. `busy` is high for exactly 3 cycles.
- R3: Each A/B pair of a shift command moves the chain one place toward `scan_out`. Stage 0 (bit 0 of `par_q`) takes `scan_in`, and stage i takes stage i-1. `scan_out` always shows the last stage.
- R4: A shift command (code 2'b10) performs `op_len` A/B pairs, with 0 treated as 1. `busy` is high for 4*L-1 cycles, where L is the effective count.
- R5: A flush command (code 2'b11) holds A and B high together for `op_len` cycles, with 0 treated as 1. During that time `scan_out` follows `scan_in` with no clock edge. Afterwards every stage holds the last `scan_in` value.
- R6: Phase C is never high together with A or B. A and B are high together only during a flush. Every rising phase is preceded by a cycle with all phases low.
- R7: A command presented while `busy` is high is ignored. So is the code 2'b00 at any time.
- R8: `busy` stays high until the final B pulse of the sequence has ended, and drops in the cycle right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the phases are derived from it |
| rst_n | input | 1 | Active-low synchronous reset of the sequencer |
| cmd_valid | input | 1 | Command strobe, sampled on the rising edge |
| cmd | input | 2 | 00 none, 01 capture, 10 shift, 11 flush |
| op_len | input | CNT_W | Pair count for shift, cycle count for flush |
| par_d | input | STAGES | System data captured by phase C |
| scan_in | input | 1 | Serial data into stage 0 |
| par_q | output | STAGES | Second-latch contents; bit i is stage i |
| scan_out | output | 1 | Second latch of the last stage |
| busy | output | 1 | A phase sequence is in progress |

## Verification
The assertions assume that `par_d` and `scan_in` do not change in the cycles in which C or A is pulsed, except during a flush, when `scan_in` is meant to ripple through. They also assume that reset is held for at least one clock edge before any command. The bench changes inputs only on falling edges. It sets `par_d` and `scan_in` before it issues a capture or shift and holds them until `busy` drops. It toggles `scan_in` only while a flush is running.

// File: rtl/lssd_pkg.sv
package lssd_pkg;
   typedef enum logic [1:0] {
      OP_NONE    = 2'b00,
      OP_CAPTURE = 2'b01,
      OP_SHIFT   = 2'b10,
      OP_FLUSH   = 2'b11
   } lssd_op_e;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_P1,
      SQ_G1,
      SQ_P2,
      SQ_G2,
      SQ_FLUSH
   } lssd_seq_e;
endpackage

// File: rtl/lssd_phase_seq.sv
module lssd_phase_seq
   import lssd_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [1:0]       cmd,
   input  logic [CNT_W-1:0] op_len,
   output logic             ph_a,
   output logic             ph_b,
   output logic             ph_c,
   output logic             busy,
   output logic             flushing
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   lssd_seq_e        state_q, state_d;
   logic [CNT_W-1:0] remain_q, remain_d;
   logic             shift_q, shift_d;
   logic             accept;
   lssd_op_e         op;
   logic [CNT_W-1:0] eff_len;

   assign op      = lssd_op_e'(cmd);
   assign accept  = cmd_valid && (state_q == SQ_IDLE) && (op != OP_NONE);
   assign eff_len = (op_len == '0) ? ONE : op_len;

   always_comb begin
      state_d  = state_q;
      remain_d = remain_q;
      shift_d  = shift_q;
      unique case (state_q)
         SQ_IDLE: begin
            if (accept) begin
               shift_d  = (op == OP_SHIFT);
               remain_d = (op == OP_CAPTURE) ? ONE : eff_len;
               state_d  = (op == OP_FLUSH) ? SQ_FLUSH : SQ_P1;
            end
         end
         SQ_P1: state_d = SQ_G1;
         SQ_G1: state_d = SQ_P2;
         SQ_P2: begin
            if (remain_q == ONE) begin
               state_d = SQ_IDLE;
            end else begin
               state_d  = SQ_G2;
               remain_d = remain_q - ONE;
            end
         end
         SQ_G2: state_d = SQ_P1;
         SQ_FLUSH: begin
            if (remain_q == ONE) begin
               state_d = SQ_IDLE;
            end else begin
               remain_d = remain_q - ONE;
            end
         end
         default: state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= SQ_IDLE;
         remain_q <= '0;
         shift_q  <= 1'b0;
         ph_a     <= 1'b0;
         ph_b     <= 1'b0;
         ph_c     <= 1'b0;
      end else begin
         state_q  <= state_d;
         remain_q <= remain_d;
         shift_q  <= shift_d;
         ph_a     <= ((state_d == SQ_P1) && shift_d) || (state_d == SQ_FLUSH);
         ph_b     <= (state_d == SQ_P2) || (state_d == SQ_FLUSH);
         ph_c     <= (state_d == SQ_P1) && !shift_d;
      end
   end

   assign busy     = (state_q != SQ_IDLE);
   assign flushing = (state_q == SQ_FLUSH);
endmodule

// File: rtl/lssd_latch_pair.sv
module lssd_latch_pair (
   input  logic ph_a,
   input  logic ph_b,
   input  logic ph_c,
   input  logic d_sys,
   input  logic d_scan,
   output logic q
);
   logic l1;

   always_latch begin
      if (ph_c) begin
         l1 <= d_sys;
      end else if (ph_a) begin
         l1 <= d_scan;
      end
   end

   always_latch begin
      if (ph_b) begin
         q <= l1;
      end
   end
endmodule

// File: rtl/lssd_chain.sv
module lssd_chain #(
   parameter int STAGES = 8
) (
   input  logic              ph_a,
   input  logic              ph_b,
   input  logic              ph_c,
   input  logic [STAGES-1:0] par_d,
   input  logic              scan_in,
   output logic [STAGES-1:0] par_q
);
   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic scan_src;
      if (i == 0) begin : g_head
         assign scan_src = scan_in;
      end else begin : g_link
         assign scan_src = par_q[i-1];
      end
      lssd_latch_pair i_pair (
         .ph_a  (ph_a),
         .ph_b  (ph_b),
         .ph_c  (ph_c),
         .d_sys (par_d[i]),
         .d_scan(scan_src),
         .q     (par_q[i])
      );
   end
endmodule

// File: rtl/lssd_scan_reg.sv
module lssd_scan_reg #(
   parameter int STAGES = 8,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd,
   input  logic [CNT_W-1:0]  op_len,
   input  logic [STAGES-1:0] par_d,
   input  logic              scan_in,
   output logic [STAGES-1:0] par_q,
   output logic              scan_out,
   output logic              busy
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 1) begin : g_bad_stages
      $error("lssd_scan_reg: STAGES must be at least 1");
   end
   if (CNT_W < 1 || CNT_W > 31) begin : g_bad_cnt
      $error("lssd_scan_reg: CNT_W must lie in 1..31");
   end

   logic ph_a, ph_b, ph_c, flushing;

   lssd_phase_seq #(.CNT_W(CNT_W)) i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_valid(cmd_valid),
      .cmd      (cmd),
      .op_len   (op_len),
      .ph_a     (ph_a),
      .ph_b     (ph_b),
      .ph_c     (ph_c),
      .busy     (busy),
      .flushing (flushing)
   );

   lssd_chain #(.STAGES(STAGES)) i_chain (
      .ph_a   (ph_a),
      .ph_b   (ph_b),
      .ph_c   (ph_c),
      .par_d  (par_d),
      .scan_in(scan_in),
      .par_q  (par_q)
   );

   assign scan_out = par_q[LAST];
endmodule

// File: rtl/lssd_scan_reg_chk.sv
module lssd_scan_reg_chk (
   input logic clk,
   input logic rst_n,
   input logic ph_a,
   input logic ph_b,
   input logic ph_c,
   input logic flushing,
   input logic busy
);
   p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!ph_a && !ph_b && !ph_c));

   p_c_alone_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ph_c |-> (!ph_a && !ph_b));

   p_ab_only_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_a && ph_b) |-> flushing);

   p_gap_before_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ph_a) || $rose(ph_b) || $rose(ph_c)) |-> $past(!ph_a && !ph_b && !ph_c));

   p_busy_ends_after_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(ph_b));

   p_b_implies_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ph_b |-> busy);
endmodule

bind lssd_scan_reg lssd_scan_reg_chk i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ph_a    (ph_a),
   .ph_b    (ph_b),
   .ph_c    (ph_c),
   .flushing(flushing),
   .busy    (busy)
);

// File: tb/test_lssd_scan_reg.sv
module test_lssd_scan_reg;
   localparam int N  = 8;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [1:0]    cmd = 2'b00;
   logic [CW-1:0] op_len = '0;
   logic [N-1:0]  par_d = '0;
   logic          scan_in = 1'b0;
   logic [N-1:0]  par_q;
   logic          scan_out;
   logic          busy;

   int n_chk = 0;
   int n_bad = 0;
   logic [N-1:0] exp_q;

   always #5 clk = ~clk;

   lssd_scan_reg #(.STAGES(N), .CNT_W(CW)) i_lssd_scan_reg (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
      .op_len(op_len), .par_d(par_d), .scan_in(scan_in),
      .par_q(par_q), .scan_out(scan_out), .busy(busy)
   );

   task automatic chk(input logic ok, input string req, input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, expv);
      end
   endtask

   task automatic issue(input logic [1:0] c, input int len, output int bcy);
      @(negedge clk);
      cmd_valid = 1'b1; cmd = c; op_len = len[CW-1:0];
      @(negedge clk);
      cmd_valid = 1'b0; cmd = 2'b00;
      bcy = 0;
      while (busy && bcy < 2000) begin
         bcy++;
         @(negedge clk);
      end
   endtask

   task automatic model_shift(input logic b, input int pairs);
      for (int k = 0; k < pairs; k++) exp_q = {exp_q[N-2:0], b};
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(busy == 1'b0, "R1 busy after reset", busy, 0);
   endtask

   task automatic t_flush(input int len, input int exp_cy);
      int bcy = 0;
      @(negedge clk);
      cmd_valid = 1'b1; cmd = 2'b11; op_len = len[CW-1:0];
      @(negedge clk);
      cmd_valid = 1'b0; cmd = 2'b00;
      while (busy && bcy < 2000) begin
         bcy++;
         scan_in = ~scan_in;
         #1;
         chk(scan_out == scan_in, "R5 flush transparency", scan_out, scan_in);
         @(negedge clk);
      end
      chk(bcy == exp_cy, "R5 flush length", bcy, exp_cy);
      exp_q = {N{scan_in}};
      chk(par_q == exp_q, "R5 state after flush", par_q, exp_q);
   endtask

   task automatic t_capture(input logic [N-1:0] pat);
      int bcy;
      par_d = pat;
      issue(2'b01, 0, bcy);
      exp_q = pat;
      chk(par_q == exp_q, "R2 captured data", par_q, exp_q);
      chk(bcy == 3, "R2 capture busy length", bcy, 3);
      chk(bcy == 3, "R8 busy ends after B", bcy, 3);
   endtask

   task automatic t_shift_out_in(input logic [N-1:0] nxt);
      int bcy;
      for (int k = 0; k < N; k++) begin
         chk(scan_out == exp_q[N-1], "R3 scan_out bit", scan_out, exp_q[N-1]);
         scan_in = nxt[k];
         issue(2'b10, 1, bcy);
         model_shift(nxt[k], 1);
         chk(par_q == exp_q, "R3 chain after one shift", par_q, exp_q);
         chk(bcy == 3, "R4 single pair busy", bcy, 3);
      end
   endtask

   task automatic t_shift_multi(input logic b, input int len, input int eff);
      int bcy;
      scan_in = b;
      issue(2'b10, len, bcy);
      model_shift(b, eff);
      chk(par_q == exp_q, "R4 multi shift data", par_q, exp_q);
      chk(bcy == 4 * eff - 1, "R4 multi shift busy", bcy, 4 * eff - 1);
   endtask

   task automatic t_ignore_busy;
      int bcy = 0;
      scan_in = 1'b1;
      par_d = 8'h5A;
      @(negedge clk);
      cmd_valid = 1'b1; cmd = 2'b10; op_len = 8'd2;
      @(negedge clk);
      cmd = 2'b01; par_d = 8'h5A;
      while (busy && bcy < 2000) begin
         bcy++;
         if (bcy == 3) begin cmd_valid = 1'b0; cmd = 2'b00; end
         @(negedge clk);
      end
      cmd_valid = 1'b0; cmd = 2'b00;
      model_shift(1'b1, 2);
      chk(bcy == 7, "R7 busy unaffected by late command", bcy, 7);
      chk(par_q == exp_q, "R7 late capture ignored", par_q, exp_q);
      @(negedge clk);
      chk(busy == 1'b0, "R7 no queued command", busy, 0);
   endtask

   task automatic t_none_cmd;
      par_d = ~exp_q;
      @(negedge clk);
      cmd_valid = 1'b1; cmd = 2'b00; op_len = 8'd3;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(busy == 1'b0, "R7 none code leaves idle", busy, 0);
      @(negedge clk);
      chk(par_q == exp_q, "R7 none code keeps state", par_q, exp_q);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      scan_in = 1'b1;
      t_flush(12, 12);
      t_flush(0, 1);
      t_capture(8'hA5);
      t_shift_out_in(8'h3C);
      t_capture(8'h96);
      t_shift_multi(1'b0, 3, 3);
      t_shift_multi(1'b1, 0, 1);
      t_ignore_busy();
      t_none_cmd();
      t_capture(8'h0F);
      t_shift_out_in(8'hF1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule